// File: doc/BRIEF.md
# Floating-Point Status Word with Error Summary

This block keeps the 16-bit status word of a floating-point unit. It collects sticky exception flags from the execution unit and holds the condition codes, the top-of-stack pointer and a stack-fault flag. It also forms an error summary from the flags and the exception masks supplied by the control word. The summary drives an ERROR pin and is copied into a legacy busy bit. Both of these bits are derived values and are never stored, so they follow any change of flags or masks without delay.

Environment-restore operations load the whole word in one cycle. The stored fields take the loaded values, but bits 7 and 15 of the loaded data are discarded. If a restore leaves an unmasked flag set, ERROR rises as soon as the load is registered.

Top module: `fpu_status_word`

## Requirements
- R1: While reset is active and in the first cycle after it, `status_o` is 16'h0000 and `error_o` is 0.
- R2: A 1 on `exc_set[i]` sets status bit i (i in 0..5) at the next clock edge. The bit then holds until reset, `exc_clr` or `ld_en`.
- R3: Status bit 7 is 1 exactly when some bit i in 5:0 is 1 while `mask_in[i]` is 0, where a mask bit of 1 means masked. The bit follows `mask_in` within the same cycle.
- R4: Status bit 15 always equals status bit 7.
- R5: `error_o` always equals status bit 7.
- R6: With `top_we` high, `top_in` appears in status bits 13:11 after the next edge. Otherwise those bits hold.
- R7: With `cc_we` high, `cc_in[0]`, `cc_in[1]`, `cc_in[2]` and `cc_in[3]` go to status bits 8, 9, 10 and 14 at the next edge. Otherwise those bits hold.
- R8: A `stk_fault` cycle sets bit 6 (stack flag) and bit 0 (invalid operation), and it writes bit 9 with `stk_ovf` (1 = overflow, 0 = underflow). This write to bit 9 wins over `cc_in[1]` in the same cycle.
- R9: `exc_clr` clears bits 5:0 and bit 6 at the next edge, and any flag sets or stack-fault sets in the same cycle are lost.
- R10: With `ld_en` high, the next edge loads bits 6:0 except 7, 8 to 14 from `ld_word`, so bits 5:0, 6, 8, 9, 10, 13:11 and 14 take the loaded values. Every other update in that cycle is ignored. Bits 7 and 15 of `ld_word` have no effect. Both bits are recomputed from the loaded flags and the current `mask_in`, so `error_o` is valid in the first cycle after the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_set | input | 6 | Exception-set pulses, one per flag |
| exc_clr | input | 1 | Clear all exception flags and the stack flag |
| cc_we | input | 1 | Condition-code write enable |
| cc_in | input | 4 | New condition codes C3..C0 |
| top_we | input | 1 | TOP write enable |
| top_in | input | 3 | New top-of-stack index |
| stk_fault | input | 1 | Stack fault detected |
| stk_ovf | input | 1 | Fault direction: 1 overflow, 0 underflow |
| mask_in | input | 6 | Exception masks from the control word, 1 = masked |
| ld_en | input | 1 | Full-word load strobe |
| ld_word | input | 16 | Word to load |
| status_o | output | 16 | Status word for readback |
| error_o | output | 1 | Error output, high when the summary bit is set |

## Verification
The checker confirms on every cycle that the summary bit matches the unmasked flags and that the busy bit and ERROR follow it. It also covers flag stickiness, the effect of a stack fault, clearing, and the fields written by a load. The remaining behaviour appears only in the bench scenarios. Those scenarios compare the whole word against a behavioural model in every cycle. They cover same-cycle collisions (a load against sets, a clear against a fault, a fault against a condition-code write), loads whose bits 7 and 15 disagree with the recomputed summary, and masks that change while flags are held.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
   localparam int unsigned SW_W    = 16;
   localparam int unsigned INV_BIT = 0;
   localparam int unsigned SF_BIT  = 6;
   localparam int unsigned ES_BIT  = 7;
   localparam int unsigned C0_BIT  = 8;
   localparam int unsigned C1_BIT  = 9;
   localparam int unsigned C2_BIT  = 10;
   localparam int unsigned TOP_LSB = 11;
   localparam int unsigned C3_BIT  = 14;
   localparam int unsigned B_BIT   = 15;
endpackage

// File: rtl/fsw_flag_cell.sv
module fsw_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_en,
   input  logic ld_val,
   input  logic clr,
   input  logic set,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (ld_en) q <= ld_val;
      else if (clr)   q <= 1'b0;
      else if (set)   q <= 1'b1;
   end
endmodule

// File: rtl/fsw_field_regs.sv
module fsw_field_regs #(
   parameter int unsigned NUM_CC = 4,
   parameter int unsigned TOP_W  = 3,
   parameter int unsigned DIR_CC = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [NUM_CC-1:0] ld_cc,
   input  logic [TOP_W-1:0]  ld_top,
   input  logic              cc_we,
   input  logic [NUM_CC-1:0] cc_in,
   input  logic              top_we,
   input  logic [TOP_W-1:0]  top_in,
   input  logic              stk_fault,
   input  logic              stk_ovf,
   output logic [NUM_CC-1:0] cc_q,
   output logic [TOP_W-1:0]  top_q
);
   logic [NUM_CC-1:0] cc_nxt;

   always_comb begin
      cc_nxt = cc_we ? cc_in : cc_q;
      if (stk_fault) cc_nxt[DIR_CC] = stk_ovf;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cc_q  <= '0;
         top_q <= '0;
      end else if (ld_en) begin
         cc_q  <= ld_cc;
         top_q <= ld_top;
      end else begin
         cc_q <= cc_nxt;
         if (top_we) top_q <= top_in;
      end
   end
endmodule

// File: rtl/fsw_summary.sv
module fsw_summary #(
   parameter int unsigned NUM_EXC = 6
) (
   input  logic [NUM_EXC-1:0] flags,
   input  logic [NUM_EXC-1:0] mask,
   output logic               es
);
   assign es = |(flags & ~mask);
endmodule

// File: rtl/fpu_status_word.sv
module fpu_status_word #(
   parameter int unsigned NUM_EXC = 6,
   parameter int unsigned NUM_CC  = 4,
   parameter int unsigned TOP_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_EXC-1:0]       exc_set,
   input  logic                     exc_clr,
   input  logic                     cc_we,
   input  logic [NUM_CC-1:0]        cc_in,
   input  logic                     top_we,
   input  logic [TOP_W-1:0]         top_in,
   input  logic                     stk_fault,
   input  logic                     stk_ovf,
   input  logic [NUM_EXC-1:0]       mask_in,
   input  logic                     ld_en,
   input  logic [fsw_pkg::SW_W-1:0] ld_word,
   output logic [fsw_pkg::SW_W-1:0] status_o,
   output logic                     error_o
);
   import fsw_pkg::*;

   localparam int unsigned NCELL = NUM_EXC + 1;

   if (NUM_EXC != SF_BIT) begin : g_bad_exc
      $error("NUM_EXC must fill the bits below the stack flag");
   end
   if (NUM_CC != 4) begin : g_bad_cc
      $error("NUM_CC must be 4");
   end
   if (TOP_W != C3_BIT - TOP_LSB) begin : g_bad_top
      $error("TOP_W must fill the field between C2 and C3");
   end

   logic [NCELL-1:0]  cell_set;
   logic [NCELL-1:0]  cell_ld;
   logic [NCELL-1:0]  cell_q;
   logic [NUM_EXC-1:0] flags;
   logic              sf;
   logic              es;
   logic [NUM_CC-1:0] cc_q;
   logic [TOP_W-1:0]  top_q;
   logic [NUM_CC-1:0] ld_cc;

   always_comb begin
      cell_set             = {1'b0, exc_set};
      cell_set[INV_BIT]    = exc_set[INV_BIT] | stk_fault;
      cell_set[NUM_EXC]    = stk_fault;
      cell_ld              = ld_word[NCELL-1:0];
   end

   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      fsw_flag_cell u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_en  (ld_en),
         .ld_val (cell_ld[i]),
         .clr    (exc_clr),
         .set    (cell_set[i]),
         .q      (cell_q[i])
      );
   end

   assign flags = cell_q[NUM_EXC-1:0];
   assign sf    = cell_q[NUM_EXC];
   assign ld_cc = {ld_word[C3_BIT], ld_word[C2_BIT], ld_word[C1_BIT], ld_word[C0_BIT]};

   fsw_field_regs #(
      .NUM_CC (NUM_CC),
      .TOP_W  (TOP_W),
      .DIR_CC (C1_BIT - C0_BIT)
   ) u_fields (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_en),
      .ld_cc     (ld_cc),
      .ld_top    (ld_word[TOP_LSB +: TOP_W]),
      .cc_we     (cc_we),
      .cc_in     (cc_in),
      .top_we    (top_we),
      .top_in    (top_in),
      .stk_fault (stk_fault),
      .stk_ovf   (stk_ovf),
      .cc_q      (cc_q),
      .top_q     (top_q)
   );

   fsw_summary #(.NUM_EXC(NUM_EXC)) u_sum (
      .flags (flags),
      .mask  (mask_in),
      .es    (es)
   );

   always_comb begin
      status_o                      = '0;
      status_o[NUM_EXC-1:0]         = flags;
      status_o[SF_BIT]              = sf;
      status_o[ES_BIT]              = es;
      status_o[C0_BIT]              = cc_q[0];
      status_o[C1_BIT]              = cc_q[1];
      status_o[C2_BIT]              = cc_q[2];
      status_o[TOP_LSB +: TOP_W]    = top_q;
      status_o[C3_BIT]              = cc_q[3];
      status_o[B_BIT]               = es;
   end

   assign error_o = es;
endmodule

// File: rtl/fsw_status_chk.sv
module fsw_status_chk #(
   parameter int unsigned NUM_EXC = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EXC-1:0] exc_set,
   input logic               exc_clr,
   input logic               stk_fault,
   input logic               stk_ovf,
   input logic [NUM_EXC-1:0] mask_in,
   input logic               ld_en,
   input logic [15:0]        ld_word,
   input logic [15:0]        status_o,
   input logic               error_o
);
   // R3
   summary_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] == |(status_o[5:0] & ~mask_in));
   // R4
   busy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[15] == status_o[7]);
   // R5
   error_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error_o == status_o[7]);
   // R2
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && !exc_clr) |=>
         ((status_o[5:0] & $past(status_o[5:0] | exc_set)) == $past(status_o[5:0] | exc_set)));
   // R8
   stack_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_fault && !ld_en && !exc_clr) |=>
         (status_o[6] && status_o[0] && status_o[9] == $past(stk_ovf)));
   // R9
   clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_clr && !ld_en) |=> (status_o[6:0] & 7'h3f) == 7'h00 && !status_o[6]);
   // R10
   load_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> ({status_o[14:8], status_o[6:0]} == $past({ld_word[14:8], ld_word[6:0]})));
endmodule

bind fpu_status_word fsw_status_chk #(.NUM_EXC(NUM_EXC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exc_set   (exc_set),
   .exc_clr   (exc_clr),
   .stk_fault (stk_fault),
   .stk_ovf   (stk_ovf),
   .mask_in   (mask_in),
   .ld_en     (ld_en),
   .ld_word   (ld_word),
   .status_o  (status_o),
   .error_o   (error_o)
);

// File: tb/sim_fpu_status_word.sv
`timescale 1ns/1ps
module sim_fpu_status_word;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  exc_set = '0;
   logic        exc_clr = 1'b0;
   logic        cc_we = 1'b0;
   logic [3:0]  cc_in = '0;
   logic        top_we = 1'b0;
   logic [2:0]  top_in = '0;
   logic        stk_fault = 1'b0;
   logic        stk_ovf = 1'b0;
   logic [5:0]  mask_in = 6'h3f;
   logic        ld_en = 1'b0;
   logic [15:0] ld_word = '0;
   logic [15:0] status_o;
   logic        error_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fpu_status_word u0 (.*);

   // behavioural reference state
   bit [5:0] m_flag;
   bit       m_sf;
   bit       m_c[4];
   int       m_top;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_flag = 0; m_sf = 0; m_top = 0;
         foreach (m_c[k]) m_c[k] = 0;
      end else if (ld_en) begin
         m_flag = ld_word[5:0];
         m_sf   = ld_word[6];
         m_c[0] = ld_word[8]; m_c[1] = ld_word[9];
         m_c[2] = ld_word[10]; m_c[3] = ld_word[14];
         m_top  = int'(ld_word[13:11]);
      end else begin
         if (cc_we) for (int k = 0; k < 4; k++) m_c[k] = cc_in[k];
         if (stk_fault) m_c[1] = stk_ovf;
         if (top_we) m_top = int'(top_in);
         if (exc_clr) begin
            m_flag = 0; m_sf = 0;
         end else begin
            for (int k = 0; k < 6; k++) if (exc_set[k]) m_flag[k] = 1;
            if (stk_fault) begin m_flag[0] = 1; m_sf = 1; end
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit es = 0;
      for (int k = 0; k < 6; k++) if (m_flag[k] && !mask_in[k]) es = 1;
      check("R2 R8 R9 R10 flags", int'(status_o[5:0]), int'(m_flag));
      check("R8 R9 R10 stack flag", int'(status_o[6]), int'(m_sf));
      check("R3 summary", int'(status_o[7]), int'(es));
      check("R4 busy mirror", int'(status_o[15]), int'(es));
      check("R5 error pin", int'(error_o), int'(es));
      check("R6 R10 top", int'(status_o[13:11]), m_top);
      check("R7 R8 R10 cond codes",
            int'({status_o[14], status_o[10], status_o[9], status_o[8]}),
            int'({m_c[3], m_c[2], m_c[1], m_c[0]}));
   endtask

   always @(negedge clk) if (rst_n && !done) compare();

   // inputs change a quarter period after the falling edge
   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic idle();
      exc_set = 0; exc_clr = 0; cc_we = 0; top_we = 0;
      stk_fault = 0; ld_en = 0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 word in reset", int'(status_o), 0);
      check("R1 error in reset", int'(error_o), 0);
      #1 rst_n = 1'b1;
      step();
      check("R1 word after reset", int'(status_o), 0);

      // R2 masked flags: no error
      exc_set = 6'b010010; step(); idle(); step();
      // R3 unmask one raised flag: error same cycle
      mask_in = 6'b101111; step();
      mask_in = 6'b111101; step();
      mask_in = 6'h3f; step();
      // R7 R6
      cc_we = 1; cc_in = 4'b1010; top_we = 1; top_in = 3'd5; step(); idle(); step();
      cc_we = 1; cc_in = 4'b0101; step(); idle();
      // R8 overflow with competing C1 write
      stk_fault = 1; stk_ovf = 1; cc_we = 1; cc_in = 4'b0000; step(); idle(); step();
      stk_fault = 1; stk_ovf = 0; step(); idle(); step();
      // R9 clear with simultaneous sets and fault
      exc_clr = 1; exc_set = 6'h3f; stk_fault = 1; stk_ovf = 1; step(); idle(); step();
      // R10 load with bits 7/15 set but all masked
      mask_in = 6'h3f;
      ld_en = 1; ld_word = 16'h8084; exc_set = 6'h3f; step(); idle(); step();
      // R10 load unmasked flag, bits 7/15 clear in data
      mask_in = 6'b111011;
      ld_en = 1; ld_word = 16'h7f7c; stk_fault = 1; top_we = 1; top_in = 3'd1; step(); idle(); step();
      mask_in = 6'h3f; step();

      // mixed traffic
      for (int i = 0; i < 2000; i++) begin
         idle();
         exc_set   = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
         exc_clr   = ($urandom % 16 == 0);
         cc_we     = ($urandom % 3 == 0);
         cc_in     = 4'($urandom);
         top_we    = ($urandom % 3 == 0);
         top_in    = 3'($urandom);
         stk_fault = ($urandom % 10 == 0);
         stk_ovf   = 1'($urandom);
         mask_in   = ($urandom % 5 == 0) ? 6'($urandom) : mask_in;
         ld_en     = ($urandom % 20 == 0);
         ld_word   = 16'($urandom);
         step();
      end
      idle(); step(); step();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule